// File: doc/BRIEF.md
# Wavefront Integer Carry-Chain ALU

This block performs 32-bit integer addition and subtraction for every lane of a 64-lane SIMD wavefront in a single registered step. Each lane takes two operands. Where the opcode calls for it, the lane also takes one incoming carry or borrow bit from a shared 64-bit scalar mask. The lane produces a 32-bit result and, for the carry-producing opcodes, one carry or borrow bit. The outgoing carry bits are packed into a 64-bit scalar mask, with each bit at the index of the lane that produced it.

The surrounding datapath presents one operation per valid cycle together with an execute mask. One cycle later it receives the results, a per-lane write-enable vector, a single write-enable for the carry mask and an illegal-opcode flag. With these signals it can commit the vector results and the scalar mask, or drop them. Lanes switched off by the execute mask write nothing and contribute a zero carry bit. Plain add and subtract opcodes write the vector results only.

Top module: `wfa_carry_alu`

## Requirements
- R1: Opcode 25 adds operand 0 and operand 1. The lane result is the low 32 bits of the sum, and the lane's carry bit is bit 32 of the sum taken at 33 bits.
- R2: Opcode 26 subtracts operand 1 from operand 0. The carry bit of the lane is its borrow, which is 1 exactly when operand 0 is less than operand 1 as unsigned values.
- R3: Opcodes 27 and 30 swap the subtraction order. The lane computes operand 1 minus operand 0, and opcode 30 also subtracts the incoming borrow.
- R4: Opcode 28 adds operand 0, operand 1 and bit i of the carry-in mask for lane i, and produces a carry as in R1.
- R5: Opcode 29 computes operand 0 minus operand 1 minus bit i of the carry-in mask, and produces a borrow when the exact result is negative.
- R6: Opcodes 52, 53 and 54 give add, subtract and reversed subtract with results only. For these opcodes the carry-mask write-enable stays low and the carry mask output is zero.
- R7: The carry or borrow of lane i appears at bit i of the output carry mask. The result of lane i occupies bits 32*i+31 down to 32*i of the result vector.
- R8: A lane whose execute-mask bit is 0 has its write-enable low, a zero result and a zero carry-mask bit.
- R9: The output valid flag equals the input valid flag of the previous cycle. The outputs change only in a cycle after the input valid flag was high, and they hold otherwise.
- R10: Any opcode other than 25 to 30 and 52 to 54 raises the illegal flag. It also forces every write-enable low, the results to zero and the carry mask to zero.
- R11: After reset, every output is zero.
- R12: Opcodes that take no carry-in (25, 26, 27, 52, 53, 54) give the same outputs whatever the carry-in mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 6 | Opcode |
| in_src0 | input | 2048 | Operand 0, 32 bits per lane, lane 0 in the low bits |
| in_src1 | input | 2048 | Operand 1, 32 bits per lane |
| in_cin | input | 64 | Carry/borrow-in mask, one bit per lane |
| in_exec | input | 64 | Execute mask, one bit per lane |
| out_valid | output | 1 | Registered outputs hold a new operation |
| out_result | output | 2048 | Per-lane 32-bit results |
| out_cmask | output | 64 | Carry/borrow-out mask |
| out_lane_we | output | 64 | Per-lane destination write-enable |
| out_cmask_we | output | 1 | Carry mask write-enable |
| out_illegal | output | 1 | The opcode was not supported |

## Verification
On every cycle, the embedded properties check several relations. They check the one-cycle valid lag and that the outputs hold between operations. They check that no carry bit or write-enable reaches a lane that the execute mask disabled, that an illegal opcode writes nothing, and that the carry mask stays zero whenever its write-enable is low. Only the bench's scenarios can show that the arithmetic itself is correct. This covers carry and borrow at the wrap points, the swapped operand order, the use of the carry-in bit of the right lane and the placement of each lane's bits. The bench sweeps every opcode on a reduced 8-lane, 8-bit configuration and computes the expected values with signed integer arithmetic.

// File: rtl/wfa_pkg.sv
package wfa_pkg;
  localparam int OP_W = 6;

  localparam logic [OP_W-1:0] OP_ADD_CO  = 6'd25;
  localparam logic [OP_W-1:0] OP_SUB_CO  = 6'd26;
  localparam logic [OP_W-1:0] OP_SUBR_CO = 6'd27;
  localparam logic [OP_W-1:0] OP_ADD_CI  = 6'd28;
  localparam logic [OP_W-1:0] OP_SUB_CI  = 6'd29;
  localparam logic [OP_W-1:0] OP_SUBR_CI = 6'd30;
  localparam logic [OP_W-1:0] OP_ADD     = 6'd52;
  localparam logic [OP_W-1:0] OP_SUB     = 6'd53;
  localparam logic [OP_W-1:0] OP_SUBR    = 6'd54;

  // Control fields shared by every lane.
  typedef struct packed {
    logic legal;
    logic sub;
    logic rev;
    logic use_cin;
    logic wr_carry;
  } opctl_t;
endpackage

// File: rtl/wfa_decode.sv
module wfa_decode
  import wfa_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output opctl_t          ctl
);
  always_comb begin
    ctl = '0;
    unique case (op)
      OP_ADD_CO:  ctl = '{legal:1'b1, sub:1'b0, rev:1'b0, use_cin:1'b0, wr_carry:1'b1};
      OP_SUB_CO:  ctl = '{legal:1'b1, sub:1'b1, rev:1'b0, use_cin:1'b0, wr_carry:1'b1};
      OP_SUBR_CO: ctl = '{legal:1'b1, sub:1'b1, rev:1'b1, use_cin:1'b0, wr_carry:1'b1};
      OP_ADD_CI:  ctl = '{legal:1'b1, sub:1'b0, rev:1'b0, use_cin:1'b1, wr_carry:1'b1};
      OP_SUB_CI:  ctl = '{legal:1'b1, sub:1'b1, rev:1'b0, use_cin:1'b1, wr_carry:1'b1};
      OP_SUBR_CI: ctl = '{legal:1'b1, sub:1'b1, rev:1'b1, use_cin:1'b1, wr_carry:1'b1};
      OP_ADD:     ctl = '{legal:1'b1, sub:1'b0, rev:1'b0, use_cin:1'b0, wr_carry:1'b0};
      OP_SUB:     ctl = '{legal:1'b1, sub:1'b1, rev:1'b0, use_cin:1'b0, wr_carry:1'b0};
      OP_SUBR:    ctl = '{legal:1'b1, sub:1'b1, rev:1'b1, use_cin:1'b0, wr_carry:1'b0};
      default:    ctl = '0;
    endcase
  end
endmodule

// File: rtl/wfa_lane.sv
module wfa_lane
  import wfa_pkg::*;
#(
  parameter int DW = 32
) (
  input  opctl_t          ctl,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic            cin,
  input  logic            en,
  output logic [DW-1:0]   res,
  output logic            cout,
  output logic            we
);
  // One extra bit of precision: the top bit is the carry, or the borrow for subtract.
  function automatic logic [DW:0] ext_arith(input logic sub, input logic [DW-1:0] x,
                                            input logic [DW-1:0] y, input logic c);
    logic [DW:0] xe, ye, ce;
    xe = {1'b0, x};
    ye = {1'b0, y};
    ce = {{DW{1'b0}}, c};
    if (sub) ext_arith = xe - ye - ce;
    else     ext_arith = xe + ye + ce;
  endfunction

  logic [DW-1:0] opx, opy;
  logic          cbit;
  logic [DW:0]   wide;

  assign opx  = ctl.rev ? b : a;
  assign opy  = ctl.rev ? a : b;
  assign cbit = ctl.use_cin & cin;
  assign wide = ext_arith(ctl.sub, opx, opy, cbit);

  assign we   = ctl.legal & en;
  assign res  = we ? wide[DW-1:0] : '0;
  assign cout = ctl.wr_carry & en & wide[DW];
endmodule

// File: rtl/wfa_carry_alu.sv
module wfa_carry_alu
  import wfa_pkg::*;
#(
  parameter int LANES = 64,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [OP_W-1:0]     in_op,
  input  logic [LANES*DW-1:0] in_src0,
  input  logic [LANES*DW-1:0] in_src1,
  input  logic [LANES-1:0]    in_cin,
  input  logic [LANES-1:0]    in_exec,
  output logic                out_valid,
  output logic [LANES*DW-1:0] out_result,
  output logic [LANES-1:0]    out_cmask,
  output logic [LANES-1:0]    out_lane_we,
  output logic                out_cmask_we,
  output logic                out_illegal
);
  localparam int VW = LANES * DW;

  opctl_t            ctl;
  logic [VW-1:0]     lane_res;
  logic [LANES-1:0]  lane_carry;
  logic [LANES-1:0]  lane_we;
  logic              carry_we_nxt;
  logic              illegal_nxt;

  wfa_decode u_dec (.op(in_op), .ctl(ctl));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wfa_lane #(.DW(DW)) u_lane (
      .ctl  (ctl),
      .a    (in_src0[i*DW +: DW]),
      .b    (in_src1[i*DW +: DW]),
      .cin  (in_cin[i]),
      .en   (in_exec[i]),
      .res  (lane_res[i*DW +: DW]),
      .cout (lane_carry[i]),
      .we   (lane_we[i])
    );
  end

  assign carry_we_nxt = ctl.wr_carry;
  assign illegal_nxt  = ~ctl.legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_cmask    <= '0;
      out_lane_we  <= '0;
      out_cmask_we <= 1'b0;
      out_illegal  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result   <= lane_res;
        out_cmask    <= lane_carry;
        out_lane_we  <= lane_we;
        out_cmask_we <= carry_we_nxt;
        out_illegal  <= illegal_nxt;
      end
    end
  end

  // Valid lags the input by one cycle.
  p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // Outputs hold while no operation is presented.
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_cmask) && $stable(out_lane_we)));
  // No write-enable on a lane the execute mask disabled.
  p_exec_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_lane_we & ~$past(in_exec)) == '0));
  // No carry bit on a lane that does not write.
  p_carry_inactive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_cmask & ~out_lane_we) == '0));
  // An illegal opcode writes nothing.
  p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_lane_we == '0 && !out_cmask_we && out_cmask == '0));
  // The carry mask is zero whenever it is not to be written.
  p_plain_nocarry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_cmask_we |-> (out_cmask == '0));
  // The carry-producing opcodes always enable the carry-mask write.
  p_carry_we_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op >= OP_ADD_CO && in_op <= OP_SUBR_CI) |=> out_cmask_we);
endmodule

// File: tb/sim_wfa_carry_alu.sv
`timescale 1ns/1ps
module sim_wfa_carry_alu;
  localparam int L  = 8;
  localparam int W  = 8;
  localparam int VW = L * W;
  localparam longint MOD = 64'd1 << W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [5:0]    in_op = '0;
  logic [VW-1:0] in_src0 = '0, in_src1 = '0;
  logic [L-1:0]  in_cin = '0, in_exec = '0;
  logic          out_valid, out_cmask_we, out_illegal;
  logic [VW-1:0] out_result;
  logic [L-1:0]  out_cmask, out_lane_we;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wfa_carry_alu #(.LANES(L), .DW(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_src0(in_src0), .in_src1(in_src1), .in_cin(in_cin), .in_exec(in_exec),
    .out_valid(out_valid), .out_result(out_result), .out_cmask(out_cmask),
    .out_lane_we(out_lane_we), .out_cmask_we(out_cmask_we), .out_illegal(out_illegal));

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s op=%0d actual=%h expected=%h", req, what, in_op, act, exp);
    end
  endtask

  function automatic string op_tag(input int op);
    case (op)
      25: return "R1";
      26: return "R2";
      27, 30: return "R3";
      28: return "R4";
      29: return "R5";
      52, 53, 54: return "R6";
      default: return "R10";
    endcase
  endfunction

  function automatic longint edge_val(input int k);
    case (k % 6)
      0: return 0;
      1: return 1;
      2: return MOD - 1;
      3: return MOD - 2;
      4: return MOD / 2;
      default: return MOD / 2 - 1;
    endcase
  endfunction

  // Apply one operation, then compare the registered outputs one cycle later.
  task automatic run_vec(input int op, input logic [VW-1:0] s0, input logic [VW-1:0] s1,
                         input logic [L-1:0] ci, input logic [L-1:0] ex);
    logic [VW-1:0] e_res;
    logic [L-1:0]  e_cm, e_we;
    bit legal, sub, rev, usec, cw;
    legal = 1; sub = 0; rev = 0; usec = 0; cw = 1;
    case (op)
      25: ;
      26: sub = 1;
      27: begin sub = 1; rev = 1; end
      28: usec = 1;
      29: begin sub = 1; usec = 1; end
      30: begin sub = 1; rev = 1; usec = 1; end
      52: cw = 0;
      53: begin sub = 1; cw = 0; end
      54: begin sub = 1; rev = 1; cw = 0; end
      default: begin legal = 0; cw = 0; end
    endcase
    e_res = '0; e_cm = '0; e_we = '0;
    for (int l = 0; l < L; l++) begin
      longint x, y, c, r;
      x = longint'(s0[l*W +: W]);
      y = longint'(s1[l*W +: W]);
      if (rev) begin r = x; x = y; y = r; end
      c = (usec && ci[l]) ? 1 : 0;
      r = sub ? (x - y - c) : (x + y + c);
      if (legal && ex[l]) begin
        e_we[l] = 1'b1;
        e_res[l*W +: W] = W'((r % MOD + MOD) % MOD);
        if (cw) e_cm[l] = sub ? (r < 0) : (r >= MOD);
      end
    end
    @(negedge clk);
    in_op = 6'(op); in_src0 = s0; in_src1 = s1; in_cin = ci; in_exec = ex; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", "valid", longint'(out_valid), 1);
    check(op_tag(op), "result", longint'(out_result), longint'(e_res));
    check(op_tag(op), "cmask R7", longint'(out_cmask), longint'(e_cm));
    check("R8", "lane_we", longint'(out_lane_we), longint'(e_we));
    check(op_tag(op), "cmask_we", longint'(out_cmask_we), longint'(cw));
    check("R10", "illegal", longint'(out_illegal), longint'(!legal));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [VW-1:0] a, b, hold_res;
    logic [L-1:0]  ci, ex;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", "valid", longint'(out_valid), 0);
    check("R11", "result", longint'(out_result), 0);
    check("R11", "cmask", longint'({out_cmask, out_lane_we, out_cmask_we, out_illegal}), 0);
    rst_n = 1'b1;

    // Sweep all opcodes with edge values first, then random operands.
    for (int op = 0; op < 64; op++) begin
      int n;
      n = ((op >= 25 && op <= 30) || (op >= 52 && op <= 54)) ? 64 : 3;
      for (int t = 0; t < n; t++) begin
        for (int l = 0; l < L; l++) begin
          if (t < 36) begin
            a[l*W +: W] = W'(edge_val(t + l));
            b[l*W +: W] = W'(edge_val(t / 6 + l * 5));
          end else begin
            a[l*W +: W] = W'($urandom);
            b[l*W +: W] = W'($urandom);
          end
        end
        ci = (t % 3 == 0) ? '1 : L'($urandom);
        ex = (t % 4 == 0) ? '1 : L'($urandom);
        run_vec(op, a, b, ci, ex);
      end
    end

    // R12: carry-in has no effect on ops without carry-in
    for (int k = 0; k < 6; k++) begin
      int op;
      logic [VW-1:0] r0;
      logic [L-1:0]  m0;
      op = (k < 3) ? 25 + k : 49 + k;
      a = {L{W'(8'hFF)}};
      b = {L{W'(8'h01)}};
      run_vec(op, a, b, '0, '1);
      r0 = out_result; m0 = out_cmask;
      run_vec(op, a, b, '1, '1);
      check("R12", "result", longint'(out_result), longint'(r0));
      check("R12", "cmask", longint'(out_cmask), longint'(m0));
    end

    // R9: outputs hold while no operation is presented
    run_vec(25, {L{8'h80}}, {L{8'h80}}, '0, '1);
    hold_res = out_result;
    @(negedge clk);
    in_op = 6'd26; in_src0 = '1; in_src1 = '0; in_exec = '1;
    @(negedge clk);
    check("R9", "no valid", longint'(out_valid), 0);
    check("R9", "hold result", longint'(out_result), longint'(hold_res));
    check("R9", "hold cmask", longint'(out_cmask), longint'({L{1'b1}}));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule